// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Core

This block is a small stored-program processor. Code and data share one word-addressed memory of 16-bit words, and a single 16-bit accumulator holds the working value. The core steps each instruction through fetch, decode and, when an operand must be read, an execute state. It reads the instruction at the program counter and increments the counter as it fetches. It then either reads an operand into the accumulator, writes the accumulator out, or stops.

Each instruction word has two fields. Bits [15:12] hold the operation code and bits [11:0] give the memory address the operation acts on. The memory sits outside the core and is reached through a synchronous port. A read issued in one cycle returns its word in the next cycle. A write takes effect at the clock edge that ends the cycle in which it is issued.

A typical use is a short program at 0x101 that loads 2 from 0x201, adds 3 from 0x202 and 4 from 0x203, writes 9 to 0x204 and then stops. When the core stops it raises the `halted` output and makes no further memory accesses until it is reset.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low the program counter takes the value of `reset_vec` and the accumulator is cleared to zero. The first fetch after reset reads address `reset_vec`, and `halted` is low.
- R2: An instruction word carries its operation code in bits [15:12] and its operand address in bits [11:0]. Each fetch reads the word at the program counter and increments the counter by one, modulo 2^12, so the counter steps from 0xFFF to 0x000.
- R3: Operation code 2 replaces the accumulator with the word read from the operand address.
- R4: Operation code 1 adds the word read from the operand address to the accumulator, modulo 2^16, with no carry kept.
- R5: Operation code 3 raises `mem_we` for exactly one cycle, driving the operand address on `mem_addr` and the accumulator on `mem_wdata`. The accumulator is left unchanged.
- R6: Operation code 0, whatever its address field, stops the core. `halted` rises and stays high until reset, and from then on `mem_re` and `mem_we` stay low.
- R7: Operation codes 4 through 15 stop the core in the same way as code 0.
- R8: `mem_re` and `mem_we` are never high in the same cycle. Read data is taken one cycle after `mem_re`.
- R9: Measured in clock cycles, a load or an add takes 3, a store takes 2, and a stopping instruction reaches `halted` 2 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_vec | input | 12 | Start address loaded into the program counter during reset |
| mem_addr | output | 12 | Memory word address |
| mem_re | output | 1 | Read request; data is returned on `mem_rdata` in the next cycle |
| mem_we | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Write data, which is the accumulator |
| mem_rdata | input | 16 | Read data from the memory |
| halted | output | 1 | High once the core has stopped |

## Verification
The bench runs three programs, each from its own reset vector.

The first is the three-term sum, which shows that fetch, load, add and store work together. The second begins with a store, which exposes the cleared accumulator, and then adds 3 to 0xFFFF, which must wrap to 2. It ends on an undefined operation code followed by a store that must never appear on the port. The third starts at 0xFFE so the program counter crosses from 0xFFF to 0x000. It also loads a second value over an existing sum, so a load that behaved like an add would show up.

For every program the bench counts the cycles from reset release to `halted`. This separates the correct 3-cycle and 2-cycle instruction timing from timing with an extra or a missing state.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPW = 4;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_HALT
  } state_t;

  typedef enum logic [1:0] {
    K_STOP,
    K_LOAD,
    K_ADD,
    K_STORE
  } kind_t;

  localparam logic [OPW-1:0] OP_ADD   = 4'd1;
  localparam logic [OPW-1:0] OP_LOAD  = 4'd2;
  localparam logic [OPW-1:0] OP_STORE = 4'd3;

  function automatic kind_t classify(input logic [OPW-1:0] op);
    case (op)
      OP_LOAD:  return K_LOAD;
      OP_ADD:   return K_ADD;
      OP_STORE: return K_STORE;
      default:  return K_STOP;
    endcase
  endfunction
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic [DW-1:0]  word,
  output kind_t          kind,
  output logic [AW-1:0]  operand,
  output logic           undefined_op
);
  localparam int OP_LSB = DW - OPW;

  logic [OPW-1:0] opcode;

  always_comb begin
    opcode       = word[DW-1:OP_LSB];
    operand      = word[AW-1:0];
    kind         = classify(opcode);
    undefined_op = (opcode > OP_STORE);
  end
endmodule

// File: rtl/acc_control.sv
module acc_control
  import acc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  kind_t kind,
  output logic  fetch_fire,
  output logic  decode_fire,
  output logic  exec_fire,
  output logic  exec_add,
  output logic  halted
);
  state_t state, state_nx;

  always_comb begin
    fetch_fire  = (state == ST_FETCH);
    decode_fire = (state == ST_DECODE);
    exec_fire   = (state == ST_EXEC);
    halted      = (state == ST_HALT);
    state_nx    = state;
    case (state)
      ST_FETCH:  state_nx = ST_DECODE;
      ST_DECODE: begin
        case (kind)
          K_LOAD, K_ADD: state_nx = ST_EXEC;
          K_STORE:       state_nx = ST_FETCH;
          default:       state_nx = ST_HALT;
        endcase
      end
      ST_EXEC:   state_nx = ST_FETCH;
      default:   state_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FETCH;
      exec_add <= 1'b0;
    end else begin
      state <= state_nx;
      if (decode_fire) exec_add <= (kind == K_ADD);
    end
  end

  // R6: once stopped, the core stays stopped
  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9: an operand cycle always follows a decode of load or add
  assert_exec_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_fire && (kind == K_LOAD || kind == K_ADD)) |=> exec_fire);
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reset_vec,
  input  logic          fetch_fire,
  input  logic          exec_fire,
  input  logic          exec_add,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc
);
  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [AW-1:0] next_pc(input logic [AW-1:0] p);
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= reset_vec;
      acc <= '0;
    end else begin
      if (fetch_fire) pc <= next_pc(pc);
      if (exec_fire)  acc <= exec_add ? wrap_add(acc, rdata) : rdata;
    end
  end

  // R2: every fetch advances the counter by one word
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |=> pc == $past(pc) + 1'b1);

  // R3: a load leaves the fetched operand in the accumulator
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && !exec_add) |=> acc == $past(rdata));

  // R4: an add sums modulo the word width
  assert_add_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && exec_add) |=> acc == $past(acc) + $past(rdata));

  // R5: no cycle outside an operand cycle changes the accumulator
  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_fire |=> $stable(acc));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [11:0]   reset_vec,
  output logic [11:0]   mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          halted
);
  kind_t          kind;
  logic [AW-1:0]  operand;
  logic           undefined_op;
  logic           fetch_fire, decode_fire, exec_fire, exec_add;
  logic [AW-1:0]  pc;
  logic [DW-1:0]  acc;
  logic           operand_read, store_fire;

  acc_decode #(.DW(DW), .AW(AW)) u_decode (
    .word         (mem_rdata),
    .kind         (kind),
    .operand      (operand),
    .undefined_op (undefined_op)
  );

  acc_control u_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind        (kind),
    .fetch_fire  (fetch_fire),
    .decode_fire (decode_fire),
    .exec_fire   (exec_fire),
    .exec_add    (exec_add),
    .halted      (halted)
  );

  acc_datapath #(.DW(DW), .AW(AW)) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_vec  (reset_vec),
    .fetch_fire (fetch_fire),
    .exec_fire  (exec_fire),
    .exec_add   (exec_add),
    .rdata      (mem_rdata),
    .pc         (pc),
    .acc        (acc)
  );

  always_comb begin
    operand_read = decode_fire && (kind == K_LOAD || kind == K_ADD);
    store_fire   = decode_fire && (kind == K_STORE);
    mem_re       = fetch_fire || operand_read;
    mem_we       = store_fire;
    mem_addr     = fetch_fire ? pc : operand;
    mem_wdata    = acc;
  end

  // R8: one memory access per cycle
  assert_port_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R6: a stopped core stays off the memory port
  assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_re && !mem_we));

  // R7: undefined codes stop the core
  assert_undef_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_fire && undefined_op) |=> halted);

  // R5: a store lasts one cycle and is followed by a fetch
  assert_store_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && mem_re));
endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reset_vec = 12'h000;
  logic [11:0] mem_addr;
  logic        mem_re, mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0000;
  logic        halted;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_vec (reset_vec),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  // memory model: synchronous read, write at the edge
  logic [15:0] mem [int];
  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
  end

  typedef struct {
    logic [11:0] a;
    logic [15:0] d;
    string       req;
  } wr_item_t;
  wr_item_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [11:0] a, input logic [15:0] d, input string req);
    wr_item_t it;
    it.a = a; it.d = d; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: every write on the port must match the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R7", "unexpected write addr", int'(mem_addr), 0);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(mem_addr == it.a, it.req, "write addr", int'(mem_addr), int'(it.a));
        check(mem_wdata == it.d, it.req, "write data", int'(mem_wdata), int'(it.d));
      end
    end
  end

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    mem[int'(a)] = d;
  endtask

  // reset, run, and check timing and the stopped state
  task automatic run(input logic [11:0] vec, input int exp_cycles);
    int n;
    reset_vec = vec;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: first fetch targets the vector, core running
    check(mem_re && mem_addr == vec, "R1", "reset fetch addr", int'(mem_addr), int'(vec));
    check(halted == 1'b0, "R1", "halted in reset", int'(halted), 0);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!halted && n < 2000);
    check(halted, "R6", "halted reached", int'(halted), 1);
    // R9: cycle count from reset release to stop
    check(n == exp_cycles, "R9", "cycles to halt", n, exp_cycles);
    check(exp_q.size() == 0, "R5", "pending expected writes", exp_q.size(), 0);
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (!halted || mem_re || mem_we) quiet = 1'b0;
      end
      check(quiet, "R6", "stopped core stays quiet", int'(quiet), 1);
    end
  endtask

  initial begin
    // program A: three-term sum at 0x101
    put(12'h101, 16'h2201); put(12'h102, 16'h1202);
    put(12'h103, 16'h1203); put(12'h104, 16'h3204);
    put(12'h105, 16'h0ABC);
    put(12'h201, 16'd2); put(12'h202, 16'd3); put(12'h203, 16'd4); put(12'h204, 16'd0);
    expect_wr(12'h204, 16'd9, "R3/R4");
    run(12'h101, 3*3 + 2 + 2);
    check(mem[int'(12'h204)] == 16'd9, "R5", "stored sum in memory", int'(mem[int'(12'h204)]), 9);

    // program B: cleared accumulator, add wrap, undefined code stop
    put(12'h300, 16'h3310); put(12'h301, 16'h2311);
    put(12'h302, 16'h1312); put(12'h303, 16'h3313);
    put(12'h304, 16'h7123); put(12'h305, 16'h3314);
    put(12'h310, 16'hAAAA); put(12'h311, 16'hFFFF); put(12'h312, 16'h0003);
    expect_wr(12'h310, 16'h0000, "R1");
    expect_wr(12'h313, 16'h0002, "R4");
    run(12'h300, 2 + 3 + 3 + 2 + 2);
    check(mem[int'(12'h314)] != 16'hFFFF, "R7", "no store after undefined", 0, 0);

    // program C: counter wrap and load over a sum
    put(12'hFFE, 16'h2050); put(12'hFFF, 16'h1051);
    put(12'h000, 16'h3052); put(12'h001, 16'h2053);
    put(12'h002, 16'h3FFF); put(12'h003, 16'h0000);
    put(12'h050, 16'h1234); put(12'h051, 16'h1111); put(12'h053, 16'h00C7);
    expect_wr(12'h052, 16'h2345, "R2");
    expect_wr(12'hFFF, 16'h00C7, "R3");
    run(12'hFFE, 3 + 3 + 2 + 3 + 2 + 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule